// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core that completes one 32-bit instruction on every rising clock edge. It runs register arithmetic (add, sub, and, or, set-less-than), word loads and stores, two conditional branches (equal, and less-than-or-equal-to-zero) and an unconditional jump. The core holds its program counter, a 32-entry register file, the control decoders, the ALU, and word-addressed instruction and data memories.

Software is placed in the core through a load port. While reset is held high, the port writes words into either memory. Reset is then released and execution starts at address 0. A debug port reads any register combinationally, so the contents can be inspected.

Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0] and jump index [25:0]. The memories are indexed by byte address bits [MEM_AW+1:2].

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0. The load port writes the instruction memory (`ld_to_data`=0) or the data memory (`ld_to_data`=1) only while `rst` is high. Load writes made while `rst` is low are ignored.
- R2: Opcode 000000 writes rd with rs op rt. The function code selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than.
- R3: Opcode 100011 (load) writes rt with the data word at byte address rs plus the sign-extended immediate.
- R4: Opcode 101011 (store) writes rt to the data word at byte address rs plus the sign-extended immediate, and writes no register.
- R5: Opcode 000100 branches when rs equals rt. The target is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the PC becomes PC+4.
- R6: Opcode 000110 branches to the same kind of target when rs, read as a signed value, is less than or equal to zero. Otherwise the PC becomes PC+4.
- R7: Opcode 000010 jumps to {PC+4[31:28], index, 00} and writes neither a register nor memory.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Any other opcode writes nothing and moves the PC to PC+4.
- R10: Set-less-than compares signed values and writes 1 or 0. The result stays correct when the subtraction overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; enables the load port |
| ld_en | input | 1 | Load-port write strobe |
| ld_to_data | input | 1 | 0 selects instruction memory, 1 selects data memory |
| ld_addr | input | MEM_AW | Word index for the load write |
| ld_data | input | 32 | Word to load |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_val | output | 32 | Contents of the selected register |
| pc_q | output | 32 | Current program counter |

## Verification
The hardest conditions to reach from the ports are the set-less-than overflow cases and the not-taken branch paths. Both depend on register contents that can only be built by earlier instructions. The stimulus loads extreme data words (most positive, most negative, negative small) from preloaded data memory. It then runs a fixed program that compares them and tries every branch both ways, including a backward self-loop. The PC is checked on every cycle against an independently written trace, so skipped instructions and wrong targets both show up. An unknown opcode is shaped like a load to an untouched register, so any stray write would be visible.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;
  localparam logic [5:0] OP_BLEZ  = 6'b000110;

  typedef enum logic [1:0] {AOP_ADD, AOP_SUB, AOP_FUNCT} aluop_e;

  typedef struct packed {
    logic   reg_dst;
    logic   alu_src;
    logic   mem_to_reg;
    logic   reg_write;
    logic   mem_write;
    logic   br_eq;
    logic   br_lez;
    logic   jump;
    aluop_e aluop;
  } ctrl_t;

  typedef struct packed {
    logic       inv;
    logic [1:0] sel;
  } aluctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc4,
                                                    input logic [15:0] imm);
    return pc4 + (sext16(imm) << 2);
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc4,
                                                  input logic [25:0] idx);
    return {pc4[31:28], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input aluctl_t ctl);
    logic [XLEN-1:0] bb, sum;
    bb  = ctl.inv ? ~b : b;
    sum = a + bb + {{(XLEN-1){1'b0}}, ctl.inv};
    case (ctl.sel)
      2'b00:   return a & bb;
      2'b01:   return a | bb;
      2'b10:   return sum;
      default: return {{(XLEN-1){1'b0}}, (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : sum[XLEN-1]};
    endcase
  endfunction
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output aluctl_t    actl
);
  always_comb begin
    ctl = '{reg_dst: 1'b0, alu_src: 1'b0, mem_to_reg: 1'b0, reg_write: 1'b0,
            mem_write: 1'b0, br_eq: 1'b0, br_lez: 1'b0, jump: 1'b0, aluop: AOP_ADD};
    case (opcode)
      OP_RTYPE: begin ctl.reg_dst = 1'b1; ctl.reg_write = 1'b1; ctl.aluop = AOP_FUNCT; end
      OP_LOAD:  begin ctl.alu_src = 1'b1; ctl.mem_to_reg = 1'b1; ctl.reg_write = 1'b1; end
      OP_STORE: begin ctl.alu_src = 1'b1; ctl.mem_write = 1'b1; end
      OP_BEQ:   begin ctl.br_eq = 1'b1; ctl.aluop = AOP_SUB; end
      OP_BLEZ:  ctl.br_lez = 1'b1;
      OP_JUMP:  ctl.jump = 1'b1;
      default:  ;
    endcase
  end

  always_comb begin
    case (ctl.aluop)
      AOP_SUB:   actl = '{inv: 1'b1, sel: 2'b10};
      AOP_FUNCT: begin
        case (funct)
          6'b100010: actl = '{inv: 1'b1, sel: 2'b10};
          6'b100100: actl = '{inv: 1'b0, sel: 2'b00};
          6'b100101: actl = '{inv: 1'b0, sel: 2'b01};
          6'b101010: actl = '{inv: 1'b1, sel: 2'b11};
          default:   actl = '{inv: 1'b0, sel: 2'b10};
        endcase
      end
      default:   actl = '{inv: 1'b0, sel: 2'b10};
    endcase
  end

  p_store_no_regwr_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_write |-> !ctl.reg_write);
  p_jump_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_JUMP) |-> (!ctl.reg_write && !ctl.mem_write));
  p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !(ctl.aluop == AOP_FUNCT || ctl.alu_src || ctl.br_eq || ctl.br_lez || ctl.jump)
      |-> (!ctl.reg_write && !ctl.mem_write));
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [4:0]      wa,
  input  logic [XLEN-1:0] wd,
  input  logic [4:0]      ra1,
  input  logic [4:0]      ra2,
  input  logic [4:0]      ra3,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  output logic [XLEN-1:0] rd3
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != 5'd0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (ra1 == 5'd0) |-> (rd1 == '0));
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  aluctl_t         ctl,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_eval(a, b, ctl);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_to_data,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  input  logic [4:0]        dbg_sel,
  output logic [31:0]       dbg_val,
  output logic [31:0]       pc_q
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [XLEN-1:0] imem [DEPTH];
  logic [XLEN-1:0] dmem [DEPTH];
  logic [XLEN-1:0] instr, pc4, pc_next, rs_val, rt_val, alu_b, alu_y, wb_val;
  logic [4:0]      wr_reg;
  logic            alu_zero, take_br, rs_lez;
  ctrl_t           ctl;
  aluctl_t         actl;

  assign instr = imem[pc_q[MEM_AW+1:2]];

  sc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(instr[31:26]), .funct(instr[5:0]),
    .ctl(ctl), .actl(actl)
  );

  assign wr_reg = ctl.reg_dst ? instr[15:11] : instr[20:16];

  sc_regfile u_rf (
    .clk(clk), .rst(rst), .we(ctl.reg_write), .wa(wr_reg), .wd(wb_val),
    .ra1(instr[25:21]), .ra2(instr[20:16]), .ra3(dbg_sel),
    .rd1(rs_val), .rd2(rt_val), .rd3(dbg_val)
  );

  assign alu_b = ctl.alu_src ? sext16(instr[15:0]) : rt_val;

  sc_alu u_alu (.a(rs_val), .b(alu_b), .ctl(actl), .y(alu_y), .zero(alu_zero));

  assign wb_val = ctl.mem_to_reg ? dmem[alu_y[MEM_AW+1:2]] : alu_y;

  assign rs_lez  = rs_val[XLEN-1] || (rs_val == '0);
  assign take_br = (ctl.br_eq && alu_zero) || (ctl.br_lez && rs_lez);
  assign pc4     = pc_q + 32'd4;

  always_comb begin
    if (ctl.jump)     pc_next = jump_target(pc4, instr[25:0]);
    else if (take_br) pc_next = branch_target(pc4, instr[15:0]);
    else              pc_next = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst && ld_en && !ld_to_data) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst && ld_en && ld_to_data)  dmem[ld_addr] <= ld_data;
    else if (!rst && ctl.mem_write)  dmem[alu_y[MEM_AW+1:2]] <= rt_val;
  end

  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> (pc_q == '0));
  p_beq_equal_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.br_eq && take_br) |-> (rs_val == rt_val));
  p_blez_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.br_lez && !take_br) |-> ($signed(rs_val) > 0));
  p_seq_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!take_br && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4));
endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;
  localparam int AW    = 6;
  localparam int NPROG = 28;
  localparam int NPC   = 25;
  localparam int NREGC = 20;

  localparam int PC_SEQ [NPC] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,
                                  17,18,20,22,23,24,26,27,27};
  localparam int          EXP_IDX [NREGC] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,17,18,19};
  localparam logic [31:0] EXP_VAL [NREGC] = '{
    32'h0, 32'h5, 32'hFFFFFFF9, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFE,
    32'hC, 32'h1, 32'hFFFFFFFD, 32'h1, 32'h0, 32'h1, 32'hFFFFFFFE,
    32'h0, 32'h0, 32'h0, 32'h0, 32'hA, 32'h0, 32'h1234};
  localparam string EXP_TAG [NREGC] = '{
    "R8", "R3", "R3", "R3", "R3", "R2", "R2", "R2", "R2", "R10", "R10", "R10",
    "R4", "R5", "R6", "R6", "R7", "R2", "R9", "R9"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic        ld_to_data = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_val, pc_q;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sc_core #(.MEM_AW(AW)) u_sc_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_to_data(ld_to_data),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_sel(dbg_sel),
    .dbg_val(dbg_val), .pc_q(pc_q)
  );

  function automatic logic [31:0] rty(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] ity(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic load(logic to_data, int addr, logic [31:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_to_data = to_data; ld_addr = AW'(addr); ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] prog [NPROG];
    prog[0]  = ity(6'b100011, 0, 1, 0);
    prog[1]  = ity(6'b100011, 0, 2, 4);
    prog[2]  = ity(6'b100011, 0, 3, 8);
    prog[3]  = ity(6'b100011, 0, 4, 12);
    prog[4]  = rty(1, 2, 5, 6'b100000);
    prog[5]  = rty(1, 2, 6, 6'b100010);
    prog[6]  = rty(1, 2, 7, 6'b100100);
    prog[7]  = rty(1, 2, 8, 6'b100101);
    prog[8]  = rty(2, 1, 9, 6'b101010);
    prog[9]  = rty(3, 2, 10, 6'b101010);
    prog[10] = rty(4, 1, 11, 6'b101010);
    prog[11] = rty(1, 1, 0, 6'b100000);
    prog[12] = ity(6'b101011, 0, 5, 16);
    prog[13] = ity(6'b100011, 0, 12, 16);
    prog[14] = ity(6'b000100, 1, 2, 5);
    prog[15] = ity(6'b000100, 1, 1, 1);
    prog[16] = rty(1, 1, 13, 6'b100000);
    prog[17] = ity(6'b000110, 1, 0, 1);
    prog[18] = ity(6'b000110, 2, 0, 1);
    prog[19] = rty(1, 1, 14, 6'b100000);
    prog[20] = ity(6'b000110, 0, 0, 1);
    prog[21] = rty(1, 1, 15, 6'b100000);
    prog[22] = ity(6'b111111, 1, 18, 20);
    prog[23] = ity(6'b100011, 0, 19, 20);
    prog[24] = {6'b000010, 26'd26};
    prog[25] = rty(1, 1, 16, 6'b100000);
    prog[26] = rty(1, 1, 17, 6'b100000);
    prog[27] = ity(6'b000100, 0, 0, -1);

    for (int i = 0; i < NPROG; i++) load(1'b0, i, prog[i]);
    load(1'b1, 0, 32'h5);
    load(1'b1, 1, 32'hFFFFFFF9);
    load(1'b1, 2, 32'h7FFFFFFF);
    load(1'b1, 3, 32'h80000000);
    load(1'b1, 5, 32'h1234);

    @(negedge clk);
    chk("R1", pc_q, 32'h0, "pc in reset");
    rst = 1'b0;
    // PC trace: branches R5, blez R6, jump R7, unknown opcode R9
    for (int k = 0; k < NPC; k++) begin
      if (k > 0) @(negedge clk);
      chk("R5/R6/R7/R9", pc_q, 32'(PC_SEQ[k] * 4), $sformatf("pc trace step %0d", k));
    end

    // register results table
    for (int i = 0; i < NREGC; i++) begin
      dbg_sel = 5'(EXP_IDX[i]);
      #1;
      chk(EXP_TAG[i], dbg_val, EXP_VAL[i], $sformatf("register %0d", EXP_IDX[i]));
    end

    // R1: load port ignored while running (would redirect the halt loop)
    @(negedge clk);
    ld_en = 1'b1; ld_to_data = 1'b0; ld_addr = AW'(27); ld_data = {6'b000010, 26'd0};
    @(negedge clk);
    ld_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", pc_q, 32'(27 * 4), "load port ignored out of reset");

    // R1: reset mid-run returns PC to 0
    rst = 1'b1;
    @(negedge clk);
    chk("R1", pc_q, 32'h0, "pc after mid-run reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", pc_q, 32'h4, "pc restarts after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule